// File: doc/BRIEF.md
# Three-Port Parallel I/O Block with Direction Control

This block gives a host 24 general-purpose digital lines through a small register window. The lines form three byte-wide ports. The third port is split into two 4-bit halves, and each half has its own direction setting. Every pin has three signals: an output value, an output-enable and an input value. The host reads and writes the port data, sets which groups drive, and can tri-state every driver at once.

Port data written while a group is an input is held and starts driving when the group becomes an output. A group that has never been written takes the value currently seen on its pins when it becomes an output. This keeps the lines from glitching when the direction changes. Input reads return pin values that have passed through a two-stage synchronizer.

Top module: `dio_ports`

## Requirements
- R1: After reset every group is an input (`pin_oe` all 0), the drivers are enabled (offset 0xA reads 0x00), the direction register reads 0x1B, and no group counts as written.
- R2: The direction register is at offset 3. Bit 4 sets port A (pins 7:0), bit 1 sets port B (pins 15:8), bit 0 sets the low half of port C (pins 19:16) and bit 3 sets the high half of port C (pins 23:20). A bit value of 1 makes the group an input and 0 makes it an output. An output group drives its `pin_oe` bits high while drivers are enabled.
- R3: A write to offset 3 with bit 7 clear is ignored and leaves every direction and every driven value unchanged. The new directions take effect only when bit 7 is set.
- R4: Bits 2, 5, 6 and 7 of the direction register always read 0, whatever was written to them.
- R5: Data may be written to a group while it is an input. When the group then becomes an output, it drives the last value written to it.
- R6: When a group that has not been written since reset becomes an output, it drives the synchronized pin value present in the cycle of the direction write.
- R7: A data read returns the driven value for an output group. For an input group it returns the pin value through a two-flop synchronizer, so a pin change shows on the read after the second rising clock edge.
- R8: Writing 1 to bit 0 of offset 0xA forces every `pin_oe` bit low, and writing 0 restores them. Offset 0xA reads this bit in bit 0 and reads 0 in bits 7:1.
- R9: Offset 0 holds port A and offset 1 holds port B. At offset 2, data bits 3:0 belong to the low half of port C and bits 7:4 to the high half. Each half is written, driven and read back according to its own direction.
- R10: Writes to offsets other than 0, 1, 2, 3 and 0xA have no effect, and reads from those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset for both read and write |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pin_in | input | 24 | Values sampled at the pins |
| pin_out | output | 24 | Values to drive onto the pins |
| pin_oe | output | 24 | Per-pin output-enable |

## Verification
The hardest case to reach is a group that leaves input mode without ever having been written, because any earlier data write hides the pin-capture path. The bench reaches it in two ways. First it turns the low half of port C to output with nothing written to it. Then it applies a reset in the middle of the run, which clears the written state of port A after that port was written earlier, and switches port A to output. In both cases the driven value has to match the pins and not the earlier register contents.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int NGRP        = 4;
    localparam int OFS_C       = 2;
    localparam int OFS_DIR     = 3;
    localparam int OFS_BUF     = 10;
    localparam int DIR_SET_BIT = 7;

    typedef enum logic [1:0] {
        GRP_A   = 2'd0,
        GRP_B   = 2'd1,
        GRP_CLO = 2'd2,
        GRP_CHI = 2'd3
    } grp_e;

    // Direction register bit that controls each group.
    function automatic int dir_bit(input int g);
        case (g)
            0:       return 4;
            1:       return 1;
            2:       return 0;
            default: return 3;
        endcase
    endfunction

    typedef struct packed {
        logic buf_off;
    } top_state_t;

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d_in;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_out = s2_q;
endmodule

// File: rtl/dio_group.sv
module dio_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         dir_wr,
    input  logic         dir_in_new,
    input  logic [W-1:0] sync_in,
    output logic         is_in,
    output logic [W-1:0] drive_val,
    output logic [W-1:0] rd_val
);
    typedef struct packed {
        logic         is_in;
        logic         written;
        logic [W-1:0] val;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dir_wr) begin
            st_d.is_in = dir_in_new;
            if (st_q.is_in && !dir_in_new && !st_q.written)
                st_d.val = sync_in;
        end
        if (wr_en) begin
            st_d.val     = wr_data;
            st_d.written = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.is_in   <= 1'b1;
            st_q.written <= 1'b0;
            st_q.val     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_in     = st_q.is_in;
    assign drive_val = st_q.val;
    assign rd_val    = st_q.is_in ? sync_in : st_q.val;

    // R5: a data write is the value held for driving
    assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (drive_val == $past(wr_data)));

    // R6: first switch to output of an unwritten group takes the pins
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && !wr_en && is_in && !dir_in_new && !st_q.written)
        |=> (drive_val == $past(sync_in)));

    // R2: a committed direction write sets the mode
    assert_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (is_in == $past(dir_in_new)));
endmodule

// File: rtl/dio_ports.sv
module dio_ports
    import dio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [3*DATA_W-1:0] pin_in,
    output logic [3*DATA_W-1:0] pin_out,
    output logic [3*DATA_W-1:0] pin_oe
);
    localparam int PIN_W  = 3 * DATA_W;
    localparam int HALF_W = DATA_W / 2;

    top_state_t st_d, st_q;

    logic [PIN_W-1:0]  sync_pins;
    logic [PIN_W-1:0]  rd_flat;
    logic [NGRP-1:0]   grp_in;
    logic [DATA_W-1:0] dir_rb;
    logic              dir_commit;

    assign dir_commit = reg_wr && (reg_addr == ADDR_W'(OFS_DIR))
                        && reg_wdata[DIR_SET_BIT];

    dio_sync #(.W(PIN_W)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (sync_pins)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int W   = (g < 2) ? DATA_W : HALF_W;
        localparam int LSB = (g < 3) ? g * DATA_W : 2 * DATA_W + HALF_W;
        localparam int BOF = (g == 3) ? HALF_W : 0;
        localparam int OFS = (g == 3) ? OFS_C : g;

        logic         is_in_g;
        logic [W-1:0] drv_g;
        logic [W-1:0] rd_g;

        dio_group #(.W(W)) i_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr && (reg_addr == ADDR_W'(OFS))),
            .wr_data    (reg_wdata[BOF +: W]),
            .dir_wr     (dir_commit),
            .dir_in_new (reg_wdata[dir_bit(g)]),
            .sync_in    (sync_pins[LSB +: W]),
            .is_in      (is_in_g),
            .drive_val  (drv_g),
            .rd_val     (rd_g)
        );

        assign grp_in[g]          = is_in_g;
        assign rd_flat[LSB +: W]  = rd_g;
        assign pin_out[LSB +: W]  = drv_g;
        assign pin_oe[LSB +: W]   = {W{~is_in_g & ~st_q.buf_off}};
    end

    always_comb begin
        dir_rb = '0;
        for (int g = 0; g < NGRP; g++)
            dir_rb[dir_bit(g)] = grp_in[g];
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_addr == ADDR_W'(OFS_BUF))
            st_d.buf_off = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(0):       reg_rdata = rd_flat[0 +: DATA_W];
            ADDR_W'(1):       reg_rdata = rd_flat[DATA_W +: DATA_W];
            ADDR_W'(OFS_C):   reg_rdata = rd_flat[2*DATA_W +: DATA_W];
            ADDR_W'(OFS_DIR): reg_rdata = dir_rb;
            ADDR_W'(OFS_BUF): reg_rdata = {{(DATA_W-1){1'b0}}, st_q.buf_off};
            default:          reg_rdata = '0;
        endcase
    end

    // R8: a tri-state request removes every driver on the next cycle
    assert_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_BUF) && reg_wdata[0])
        |=> (pin_oe == '0));

    // R3: a direction write without the set flag changes no direction
    assert_dir_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_DIR) && !reg_wdata[DIR_SET_BIT])
        |=> $stable(grp_in));
endmodule

// File: tb/test_dio_ports.sv
module test_dio_ports;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [23:0] pin_in = 24'h3C_A5_96;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dio_ports i_dio_ports (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {is_read, addr, data, expected}
    localparam logic [20:0] VEC [0:15] = '{
        {1'b1, 4'h3, 8'h00, 8'h1B},  // R1 R2 reset directions
        {1'b1, 4'hA, 8'h00, 8'h00},  // R1 drivers enabled
        {1'b1, 4'h0, 8'h00, 8'h96},  // R7 input read A
        {1'b1, 4'h1, 8'h00, 8'hA5},  // R7 input read B
        {1'b1, 4'h2, 8'h00, 8'h3C},  // R9 input read C
        {1'b0, 4'h0, 8'h55, 8'h00},  // R5 write A while input
        {1'b1, 4'h0, 8'h00, 8'h96},  // R7 still reads pins
        {1'b0, 4'h3, 8'h8B, 8'h00},  // R2 A to output
        {1'b1, 4'h3, 8'h00, 8'h0B},  // R2
        {1'b1, 4'h0, 8'h00, 8'h55},  // R5 R7 driven value
        {1'b0, 4'h3, 8'h00, 8'h00},  // R3 no set flag
        {1'b1, 4'h3, 8'h00, 8'h0B},  // R3 unchanged
        {1'b0, 4'h3, 8'hFE, 8'h00},  // R4 reserved bits set, C low out
        {1'b1, 4'h3, 8'h00, 8'h1A},  // R4 masked readback
        {1'b1, 4'h2, 8'h00, 8'h3C},  // R6 C low drives captured pins
        {1'b1, 4'h0, 8'h00, 8'h96}   // R2 A back to input
    };

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 oe at reset", pin_oe, 24'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            if (VEC[i][20]) rd_reg(VEC[i][19:16], VEC[i][7:0], $sformatf("vector %0d", i));
            else            wr_reg(VEC[i][19:16], VEC[i][15:8]);
        end

        // R2 R6: only C low drives, with the captured nibble
        chk("R2 oe after table", pin_oe, 24'h0F_0000);
        chk("R6 C low driven", {20'h0, pin_out[19:16]}, 24'hC);

        // R7: two-flop latency on an input group
        @(negedge clk);
        pin_in[15:8] = 8'h3E;
        rd_reg(4'h1, 8'hA5, "R7 latency 0");
        @(negedge clk);
        rd_reg(4'h1, 8'hA5, "R7 latency 1");
        @(negedge clk);
        rd_reg(4'h1, 8'h3E, "R7 latency 2");

        // R8: global tri-state
        wr_reg(4'hA, 8'h01);
        chk("R8 tristated", pin_oe, 24'h0);
        rd_reg(4'hA, 8'h01, "R8 readback on");
        wr_reg(4'hA, 8'hFE);
        rd_reg(4'hA, 8'h00, "R8 readback off");
        chk("R8 re-enabled", pin_oe, 24'h0F_0000);

        // R9: split port C
        wr_reg(4'h2, 8'h7E);
        rd_reg(4'h2, 8'h3E, "R9 mixed read");
        chk("R9 C low drive", {20'h0, pin_out[19:16]}, 24'hE);
        wr_reg(4'h3, 8'h92);
        rd_reg(4'h3, 8'h12, "R9 dir readback");
        chk("R5 R9 C high drives written", {16'h0, pin_out[23:16]}, 24'h7E);
        chk("R9 oe both halves", pin_oe, 24'hFF_0000);

        // R10: unused offsets
        wr_reg(4'h5, 8'hFF);
        rd_reg(4'h5, 8'h00, "R10 unused read");
        rd_reg(4'hF, 8'h00, "R10 unused read F");
        rd_reg(4'h3, 8'h12, "R10 dir untouched");
        chk("R10 oe untouched", pin_oe, 24'hFF_0000);

        // R1 R6: reset clears written state
        wr_reg(4'hA, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 oe in reset", pin_oe, 24'h0);
        rd_reg(4'h3, 8'h1B, "R1 dir in reset");
        rd_reg(4'hA, 8'h00, "R1 buf in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_reg(4'h3, 8'h8B);
        chk("R6 A captures pins after reset", {16'h0, pin_out[7:0]}, 24'h96);
        chk("R2 A oe after reset", pin_oe, 24'h0000FF);
        rd_reg(4'h0, 8'h96, "R7 A output read");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule